// File: doc/BRIEF.md
# Queued ALU with Carry Flag

This block takes arithmetic and logic requests over a valid/ready input stream. Each request holds a 2-bit operation code and two operands. The block works out a result word and a one-bit carry/borrow flag in a single registered compute stage. It then writes the pair into an internal result queue, and the queue hands results out over a valid/ready output stream in the order the requests were accepted. It can add, subtract, bitwise AND and bitwise XOR. A synchronous, active-high reset drops every queued and in-flight result.

Both streams follow the usual rules. A request is taken on a rising clock edge where `in_valid` and `in_ready` are both high. A result is removed on an edge where `out_valid` and `out_ready` are both high. Back-pressure works as follows:
- `in_ready` drops as soon as the queue entries plus the entry held in the compute stage reach the queue depth. No accepted request can then be lost.
- While `out_ready` is low, the presented result is held unchanged.
- When the queue is neither empty nor full, a request and a removal in the same cycle are both accepted.

Top module: `queued_alu`

## Requirements
- R1: Opcode 0 adds. `out_result` is the low WIDTH bits of the zero-extended sum of a and b, and `out_ovf` is the carry out of the top bit.
- R2: Opcode 1 subtracts b from a. `out_result` is the low WIDTH bits of the zero-extended difference, and `out_ovf` is 1 exactly when b is greater than a (borrow).
- R3: Opcode 2 gives the bitwise AND of a and b, with `out_ovf` always 0.
- R4: Opcode 3 gives the bitwise XOR of a and b, with `out_ovf` always 0.
- R5: Results leave in the same order in which their requests were accepted. No result is lost, duplicated or invented.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result` and `out_ovf` stay unchanged on the next cycle.
- R7: A request accepted while the block holds nothing is not visible after the first following edge. It appears on `out_valid` after the second.
- R8: `in_ready` is high only while queued plus staged entries number fewer than DEPTH. With the output stalled, exactly DEPTH requests are accepted.
- R9: With entries queued and both streams active, a request and a removal are both accepted in the same cycle, so throughput stays at one per cycle.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1. No result accepted before the reset ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_op | input | 2 | Operation: 0 add, 1 subtract, 2 AND, 3 XOR |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | WIDTH | Result word |
| out_ovf | output | 1 | Carry (add) or borrow (subtract), 0 for logic operations |

## Verification
The hardest state to reach is the exact full boundary. Here one entry sits in the compute stage and the rest sit in the queue, so `in_ready` must already be low. The bench reaches it by holding `out_ready` low while requests arrive back to back. It counts acceptances and expects exactly DEPTH.

The bench then releases the output with input still pending, which gives simultaneous push and pop at partial fill. A reset issued with the queue half full shows whether stale results survive. Long random phases with independent valid and ready activity cover ordering under irregular stalls.

// File: rtl/qalu_pkg.sv
package qalu_pkg;
  typedef enum logic [1:0] {
    OPC_ADD = 2'd0,
    OPC_SUB = 2'd1,
    OPC_AND = 2'd2,
    OPC_XOR = 2'd3
  } opc_t;
endpackage

// File: rtl/qalu_compute.sv
module qalu_compute #(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res,
  output logic             flag
);
  import qalu_pkg::*;

  logic [WIDTH:0] wide;

  always_comb begin
    wide = '0;
    res  = '0;
    flag = 1'b0;
    unique case (opc_t'(op))
      OPC_ADD: begin
        wide = {1'b0, a} + {1'b0, b};
        res  = wide[WIDTH-1:0];
        flag = wide[WIDTH];
      end
      OPC_SUB: begin
        wide = {1'b0, a} - {1'b0, b};
        res  = wide[WIDTH-1:0];
        flag = wide[WIDTH];
      end
      OPC_AND: res = a & b;
      OPC_XOR: res = a ^ b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/qalu_fifo.sv
module qalu_fifo #(
  parameter int EW    = 33,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [EW-1:0] push_data,
  input  logic          pop,
  output logic [EW-1:0] pop_data,
  output logic [CW-1:0] count
);
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop  = pop && (count != '0);
  assign do_push = push && ((count != CW'(DEPTH)) || do_pop);
  assign pop_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/queued_alu.sv
module queued_alu #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_op,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_result,
  output logic             out_ovf
);
  localparam int EW = WIDTH + 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] c_res;
  logic             c_flag;
  logic             stg_v;
  logic [EW-1:0]    stg_d;
  logic [EW-1:0]    q_data;
  logic [CW-1:0]    q_count;
  logic             accept;

  qalu_compute #(.WIDTH(WIDTH)) u_compute (
    .op   (in_op),
    .a    (in_a),
    .b    (in_b),
    .res  (c_res),
    .flag (c_flag)
  );

  // Reserve room for the staged entry so it can always drain.
  assign in_ready = (int'(q_count) + int'(stg_v)) < DEPTH;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_v <= 1'b0;
      stg_d <= '0;
    end else begin
      stg_v <= accept;
      if (accept) stg_d <= {c_flag, c_res};
    end
  end

  qalu_fifo #(.EW(EW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (stg_v),
    .push_data (stg_d),
    .pop       (out_valid && out_ready),
    .pop_data  (q_data),
    .count     (q_count)
  );

  assign out_valid  = (q_count != '0);
  assign out_result = q_data[WIDTH-1:0];
  assign out_ovf    = q_data[WIDTH];
endmodule

// File: rtl/qalu_checker.sv
module qalu_checker #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_result,
  input logic             out_ovf
);
  localparam int IW = $clog2(DEPTH + 2) + 1;
  logic [IW-1:0] inflight;

  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else inflight <= inflight + IW'(in_valid && in_ready) - IW'(out_valid && out_ready);
  end

  // R6: stalled output holds
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_ovf)));

  // R8: acceptance only with room left
  a_r8_no_overfill: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (int'(inflight) < DEPTH));

  // R10 and R5: nothing presented without an accepted request behind it
  a_r10_no_stale: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (inflight != '0));

  // R7: two-edge latency from idle
  a_r7_latency: assert property (@(posedge clk) disable iff (rst)
    (inflight == '0 && in_valid && in_ready) |=> (!out_valid ##1 out_valid));
endmodule

bind queued_alu qalu_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_ovf    (out_ovf)
);

// File: tb/tb_queued_alu.sv
module tb_queued_alu;
  localparam int WIDTH = 32;
  localparam int DEPTH = 8;
  localparam time TCLK = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [1:0]       in_op = '0;
  logic [WIDTH-1:0] in_a = '0, in_b = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [WIDTH-1:0] out_result;
  logic             out_ovf;

  always #(TCLK/2) clk = ~clk;

  queued_alu #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_ovf(out_ovf)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [WIDTH:0] expq[$];
  logic [1:0]     opq[$];
  bit             fin, fout;
  bit             prev_stall = 0;
  logic [WIDTH:0] prev_out;

  function automatic logic [WIDTH:0] model(input logic [1:0] op,
                                           input logic [WIDTH-1:0] a, b);
    logic [WIDTH:0] w;
    case (op)
      2'd0: w = {1'b0, a} + {1'b0, b};
      2'd1: w = {1'b0, a} - {1'b0, b};
      2'd2: w = {1'b0, a & b};
      default: w = {1'b0, a ^ b};
    endcase
    return w;
  endfunction

  function automatic string tag(input logic [1:0] op);
    case (op)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, settle, score handshakes, then the edge.
  task automatic step(input bit iv, input logic [1:0] op,
                      input logic [WIDTH-1:0] a, b, input bit ordy);
    logic [WIDTH:0] e;
    logic [1:0] eo;
    @(negedge clk);
    if (prev_stall) chk("R6", {out_valid, out_ovf, out_result}, {1'b1, prev_out});
    in_valid = iv; in_op = op; in_a = a; in_b = b; out_ready = ordy;
    #1;
    fin  = in_valid && in_ready;
    fout = out_valid && out_ready;
    if (fin) begin
      expq.push_back(model(op, a, b));
      opq.push_back(op);
    end
    if (fout) begin
      if (expq.size() == 0) chk("R5", 1, 0);
      else begin
        e = expq.pop_front();
        eo = opq.pop_front();
        chk(tag(eo), {out_ovf, out_result}, e);
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_out = {out_ovf, out_result};
    @(posedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 4 * DEPTH; i++) step(0, 0, 0, 0, 1);
    chk("R5", expq.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0; out_ready = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 0;
    expq.delete(); opq.delete();
    prev_stall = 0;
    #1;
    chk("R10", {out_valid, in_ready}, 2'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int acc, both;
    void'($urandom(32'h5eed1234));
    do_reset();

    // Directed corner values
    step(1, 0, 32'hFFFF_FFFF, 32'h1, 1);          // R1 wrap with carry
    step(1, 0, 32'h1234_0000, 32'h0000_5678, 1);  // R1 no carry
    step(1, 1, 32'h0, 32'h1, 1);                  // R2 borrow
    step(1, 1, 32'h5, 32'h5, 1);                  // R2 equal, no borrow
    step(1, 1, 32'h9, 32'h3, 1);                  // R2 plain
    step(1, 2, 32'hFFFF_FFFF, 32'hF0F0_F0F0, 1);  // R3 flag stays 0
    step(1, 3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);  // R4 flag stays 0
    drain();

    // R7 latency from idle
    step(1, 0, 32'd2, 32'd3, 0);
    step(0, 0, 0, 0, 0);
    chk("R7 not yet", out_valid, 0);
    step(0, 0, 0, 0, 0);
    chk("R7 visible", out_valid, 1);
    drain();

    // R8 fill with output stalled
    acc = 0;
    for (int i = 0; i < 3 * DEPTH; i++) begin
      step(1, 2'(i), 32'(i * 77), 32'(i), 0);
      if (fin) acc++;
    end
    chk("R8 accepted", acc, DEPTH);
    chk("R8 ready low", in_ready, 0);
    drain();

    // R9 concurrent push and pop at half fill
    for (int i = 0; i < DEPTH / 2; i++) step(1, 1, 32'(i), 32'(i + 1), 0);
    step(0, 0, 0, 0, 0);
    both = 0;
    for (int i = 0; i < 20; i++) begin
      step(1, 3, $urandom, $urandom, 1);
      if (fin && fout) both++;
    end
    chk("R9 both per cycle", both, 20);
    drain();

    // Random traffic, R5 ordering under irregular stalls
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, 2'($urandom), $urandom, $urandom, ($urandom % 3) != 0);
    drain();

    // R10 reset mid-traffic drops queued results
    for (int i = 0; i < DEPTH / 2 + 1; i++) step(1, 0, 32'hDEAD, 32'(i), 0);
    do_reset();
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 0, 0, 1);
      chk("R10 no stale", out_valid, 0);
    end
    for (int i = 0; i < 500; i++)
      step(($urandom % 2) != 0, 2'($urandom), $urandom, $urandom, ($urandom % 2) != 0);
    drain();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule